// File: doc/BRIEF.md
# Fast Page Mode DRAM Cycle Controller

This block turns single-byte requests from a synchronous host port into the strobe sequences of an asynchronous DRAM. The DRAM has multiplexed address pins and an 8-bit data bus. Each host request carries a 21-bit word address. The controller splits that address into an 11-bit row and a 10-bit column and presents them on a shared 11-bit pin bus, one after the other. Writes always use the early-write form: the write strobe is low before the column strobe falls, so the column strobe latches the data. Reads enable the DRAM output only while both strobes are low and the byte is captured on the last column-strobe cycle.

A free-running interval counter raises a refresh request. The controller serves it in the idle state with a column-before-row refresh, which needs no address. When a refresh and a host request are both waiting, the refresh goes first. Every interval in the sequence is a parameter counted in clock cycles.

The host raises `host_valid` and holds the request fields steady until it sees the one-cycle `host_done` pulse. For a read, the returned byte is on `host_rdata` during that pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is applied and after it is released with no traffic, both address strobes, the write strobe and the output enable are high, `dq_oe` is 0 and `host_done` is 0.
- R2: The row is `host_addr[20:10]` on `dram_a[10:0]` during the address-setup and row phases. The column is `host_addr[9:0]` on `dram_a[9:0]` with `dram_a[10]`=0 during the column-setup and column-strobe phases. At all other times `dram_a` is 0.
- R3: A host cycle runs in this order: one setup cycle with both strobes high; T_RCD cycles with only the row strobe low; one column-setup cycle; T_CASW cycles with both strobes low; then T_RP cycles with both strobes high.
- R4: In a write cycle `dram_we_n` is low from the setup cycle through the last column-strobe cycle, so it is already low when the column strobe falls. `dram_oe_n` stays high throughout. Reads and refreshes keep `dram_we_n` high.
- R5: In a read cycle `dram_oe_n` is low exactly during the column-strobe cycles. `host_rdata` holds the byte that was on `dq_in` in the last column-strobe cycle.
- R6: `dq_oe` is 1 only in write cycles: during column setup, the column strobe and the first precharge cycle. While it is 1, `dq_out` equals the write data of the request.
- R7: `host_done` is a single-cycle pulse in the first precharge cycle of each host cycle and is never raised for a refresh.
- R8: A refresh falls due every T_REF_INT cycles after reset. It is served as T_CSR cycles with only the column strobe low, then T_RASR cycles with both strobes low (write strobe high), then T_RP precharge cycles.
- R9: When the controller is idle and a refresh is due, the refresh starts even if a host request is waiting.
- R10: A request raised while a cycle or refresh is in progress is ignored until the controller is idle, and then starts its setup cycle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request present; held until host_done |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Word address (row in upper 11 bits) |
| host_wdata | input | 8 | Write byte |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read byte, valid with host_done |
| dram_ras_n | output | 1 | Row address strobe, active low |
| dram_cas_n | output | 1 | Column address strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 11 | Multiplexed row/column address |
| dq_in | input | 8 | Data from the DRAM pins |
| dq_out | output | 8 | Data to the DRAM pins |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
Once the controller leaves idle, every strobe, address and data-enable value is fixed for each cycle of the sequence. The setup cycle appears on the clock after an idle cycle that sees a request or a due refresh. A due refresh becomes visible to the controller one cycle after the interval edge, and the first interval counts from the third edge after reset release, because of the reset synchronizer. The bench keeps a queue of expected per-cycle vectors, built from the parameters when its model decides a start, and compares one vector at every falling edge. `host_rdata` is checked only in the cycle where `host_done` is expected, against a scoreboard of earlier writes.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ASETUP,
    SEQ_ROW,
    SEQ_CSETUP,
    SEQ_COL,
    SEQ_PRECH,
    SEQ_RCAS,
    SEQ_RRAS
  } seq_state_e;

  function automatic int unsigned max_of5(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d,
                                          int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int unsigned INTERVAL = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);

  localparam int unsigned CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(INTERVAL - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    pend_d = pend_q;
    if (ack)  pend_d = 1'b0;
    if (wrap) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !ack |=> pend_q); // R8
  AST_ACK_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend_q); // R9

endmodule

// File: rtl/fpm_addr_mux.sv
module fpm_addr_mux #(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned COL_W = 10,
  parameter int unsigned PIN_W = 11
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   sel_row,
  input  logic                   sel_col,
  output logic [PIN_W-1:0]       pins
);

  localparam int unsigned ADDR_W = ROW_W + COL_W;

  logic [ROW_W-1:0] row_f;
  logic [COL_W-1:0] col_f;

  assign row_f = addr[ADDR_W-1 -: ROW_W];
  assign col_f = addr[COL_W-1:0];

  always_comb begin
    pins = '0;
    if (sel_row)      pins = PIN_W'(row_f);
    else if (sel_col) pins = PIN_W'(col_f);
  end

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_dram_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CASW = 2,
  parameter int unsigned T_RP   = 2,
  parameter int unsigned T_CSR  = 1,
  parameter int unsigned T_RASR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ref_pending,
  output logic              ref_ack,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              sel_row,
  output logic              sel_col,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned MAXT = max_of5(T_RCD, T_CASW, T_RP, T_CSR, T_RASR);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wr_q, refr_q, refr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              lat_en, cap_en, host_ph;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    refr_d  = refr_q;
    ref_ack = 1'b0;
    lat_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (ref_pending) begin
          state_d = SEQ_RCAS;
          ref_ack = 1'b1;
          refr_d  = 1'b1;
        end else if (req_valid) begin
          state_d = SEQ_ASETUP;
          lat_en  = 1'b1;
          refr_d  = 1'b0;
        end
      end
      SEQ_ASETUP: begin
        state_d = SEQ_ROW;
        cnt_d   = '0;
      end
      SEQ_ROW: if (cnt_q == CW'(T_RCD - 1)) begin
        state_d = SEQ_CSETUP;
        cnt_d   = '0;
      end
      SEQ_CSETUP: begin
        state_d = SEQ_COL;
        cnt_d   = '0;
      end
      SEQ_COL: if (cnt_q == CW'(T_CASW - 1)) begin
        state_d = SEQ_PRECH;
        cnt_d   = '0;
      end
      SEQ_PRECH: if (cnt_q == CW'(T_RP - 1)) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
      SEQ_RCAS: if (cnt_q == CW'(T_CSR - 1)) begin
        state_d = SEQ_RRAS;
        cnt_d   = '0;
      end
      SEQ_RRAS: if (cnt_q == CW'(T_RASR - 1)) begin
        state_d = SEQ_PRECH;
        cnt_d   = '0;
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign cap_en = (state_q == SEQ_COL) && (cnt_q == CW'(T_CASW - 1)) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      refr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      refr_q  <= refr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (lat_en) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= dq_in;
  end

  assign host_ph = state_q inside {SEQ_ASETUP, SEQ_ROW, SEQ_CSETUP, SEQ_COL};

  assign ras_n    = !(state_q inside {SEQ_ROW, SEQ_CSETUP, SEQ_COL, SEQ_RRAS});
  assign cas_n    = !(state_q inside {SEQ_COL, SEQ_RCAS, SEQ_RRAS});
  assign we_n     = !(wr_q && host_ph);
  assign oe_n     = !(!wr_q && state_q == SEQ_COL);
  assign sel_row  = state_q inside {SEQ_ASETUP, SEQ_ROW};
  assign sel_col  = state_q inside {SEQ_CSETUP, SEQ_COL};
  assign done     = (state_q == SEQ_PRECH) && (cnt_q == '0) && !refr_q;
  assign dq_oe    = wr_q && ((state_q inside {SEQ_CSETUP, SEQ_COL}) || done);
  assign lat_addr = addr_q;
  assign dq_out   = wdata_q;
  assign rdata    = rdata_q;

  AST_WE_SETTLED_AT_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> $stable(we_n)); // R4
  AST_OE_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ras_n && !cas_n && we_n)); // R5
  AST_BUS_OFF_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AT_RAS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ras_n)); // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !cas_n |-> $past(!cas_n)); // R8

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int unsigned ROW_BITS  = 11,
  parameter int unsigned COL_BITS  = 10,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_CASW    = 2,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_CSR     = 1,
  parameter int unsigned T_RASR    = 3,
  parameter int unsigned T_REF_INT = 200,
  localparam int unsigned ADDR_W   = ROW_BITS + COL_BITS,
  localparam int unsigned PIN_W    = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [PIN_W-1:0]  dram_a,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic [1:0]        sync_q;
  logic              rst_int_n;
  logic              ref_pending, ref_ack;
  logic              sel_row, sel_col;
  logic [ADDR_W-1:0] lat_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  fpm_refresh_timer #(.INTERVAL(T_REF_INT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ack     (ref_ack),
    .pending (ref_pending)
  );

  fpm_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .T_RCD  (T_RCD),
    .T_CASW (T_CASW),
    .T_RP   (T_RP),
    .T_CSR  (T_CSR),
    .T_RASR (T_RASR)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (host_valid),
    .req_write   (host_write),
    .req_addr    (host_addr),
    .req_wdata   (host_wdata),
    .ref_pending (ref_pending),
    .ref_ack     (ref_ack),
    .dq_in       (dq_in),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .oe_n        (dram_oe_n),
    .sel_row     (sel_row),
    .sel_col     (sel_col),
    .lat_addr    (lat_addr),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .done        (host_done),
    .rdata       (host_rdata)
  );

  fpm_addr_mux #(
    .ROW_W (ROW_BITS),
    .COL_W (COL_BITS),
    .PIN_W (PIN_W)
  ) u_amux (
    .addr    (lat_addr),
    .sel_row (sel_row),
    .sel_col (sel_col),
    .pins    (dram_a)
  );

  AST_ROW_STABLE_AT_RAS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(dram_ras_n) && dram_cas_n |-> $stable(dram_a)); // R2
  AST_COL_STABLE_AT_CAS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(dram_cas_n) && !dram_ras_n |-> $stable(dram_a)); // R2

endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;

  localparam int RCD = 2, CASW = 2, RP = 2, CSR = 1, RASR = 3, RINT = 200;
  localparam int NTX = 51;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_write;
  logic [20:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_done;
  logic [7:0]  host_rdata;
  logic        ras_n, cas_n, we_n, oe_n;
  logic [10:0] dram_a;
  logic [7:0]  dq_in, dq_out;
  logic        dq_oe;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl #(.T_RCD(RCD), .T_CASW(CASW), .T_RP(RP), .T_CSR(CSR),
                  .T_RASR(RASR), .T_REF_INT(RINT)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_done(host_done),
    .host_rdata(host_rdata), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_a(dram_a), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe));

  typedef struct {
    logic ras, cas, we, oe, dqoe, done;
    logic [10:0] a;
    string tag;
  } vec_t;

  vec_t q[$];
  vec_t cur;
  logic [7:0] ref_mem[int];
  logic [7:0] dram_mem[int];
  int tests = 0, fails = 0;
  int ref_cnt = 0, ref_over_host = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic vec_t mk(logic ras, logic cas, logic we, logic oe,
                              logic dqoe, logic done, logic [10:0] a, string tag);
    vec_t v;
    v.ras = ras; v.cas = cas; v.we = we; v.oe = oe;
    v.dqoe = dqoe; v.done = done; v.a = a; v.tag = tag;
    return v;
  endfunction

  function automatic logic [20:0] addr_of(int k);
    case (k)
      0: return 21'h000000;
      1: return 21'h1FFFFF;
      2: return 21'h0003FF;
      3: return 21'h1FFC00;
      default: return 21'((k * 40503 + 1234) % 2097152);
    endcase
  endfunction

  task automatic txn(int i, output bit wr, output logic [20:0] a, output logic [7:0] d);
    d = 8'((i * 29 + 7) % 256);
    if (i < 20)      begin wr = 1; a = addr_of(i); end
    else if (i < 40) begin wr = 0; a = addr_of(39 - i); end
    else if (i < 45) begin wr = 1; a = addr_of(i - 40); end
    else if (i < 50) begin wr = 0; a = addr_of(i - 45); end
    else             begin wr = 0; a = 21'h0ABCDE; end
  endtask

  task automatic push_host(bit wr, logic [20:0] a, string t0);
    logic [10:0] row, col;
    row = a[20:10];
    col = {1'b0, a[9:0]};
    q.push_back(mk(1, 1, !wr, 1, 0, 0, row, t0));
    for (int k = 0; k < RCD; k++) q.push_back(mk(0, 1, !wr, 1, 0, 0, row, "R3"));
    q.push_back(mk(0, 1, !wr, 1, wr, 0, col, "R3"));
    for (int k = 0; k < CASW; k++) q.push_back(mk(0, 0, !wr, wr, wr, 0, col, "R3"));
    for (int k = 0; k < RP; k++) q.push_back(mk(1, 1, 1, 1, (k == 0) ? wr : 1'b0, k == 0, 11'h0, "R3"));
  endtask

  task automatic push_ref(string t0);
    for (int k = 0; k < CSR; k++) q.push_back(mk(1, 0, 1, 1, 0, 0, 11'h0, (k == 0) ? t0 : "R8"));
    for (int k = 0; k < RASR; k++) q.push_back(mk(0, 0, 1, 1, 0, 0, 11'h0, "R8"));
    for (int k = 0; k < RP; k++) q.push_back(mk(1, 1, 1, 1, 0, 0, 11'h0, "R8"));
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=complete");
      report();
      $finish;
    end
  end

  initial begin
    bit          cur_idle, mpend, cur_wr, waited;
    logic [20:0] cur_a;
    logic [7:0]  cur_d, exp_rd;
    logic        prev_ras, prev_cas;
    logic [10:0] row_l;
    logic [9:0]  col_l;
    int E, tx, gap, tail;
    vec_t idle_v;

    idle_v = mk(1, 1, 1, 1, 0, 0, 11'h0, "R3");
    rst_n = 0; host_valid = 0; host_write = 0; host_addr = '0; host_wdata = '0;
    dq_in = 8'h5A;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(!dq_oe && !host_done, "R1", "dq_oe/done in reset", {dq_oe, host_done}, 0);
    rst_n = 1;
    cur = idle_v; cur_idle = 1; mpend = 0; E = 0; tx = 0; gap = 5; tail = 0;
    prev_ras = 1; prev_cas = 1; row_l = '0; col_l = '0;
    cur_wr = 0; cur_a = '0; cur_d = '0; waited = 0;

    while (tail < 260) begin
      @(negedge clk);
      E++;
      if (E > 2 && ((E - 2) % RINT) == 0) mpend = 1;

      chk(ras_n == cur.ras, cur.tag, "ras_n", ras_n, cur.ras);
      chk(cas_n == cur.cas, cur.tag, "cas_n", cas_n, cur.cas);
      chk(we_n == cur.we, "R4", "we_n", we_n, cur.we);
      chk(oe_n == cur.oe, "R5", "oe_n", oe_n, cur.oe);
      chk(dq_oe == cur.dqoe, "R6", "dq_oe", dq_oe, cur.dqoe);
      chk(host_done == cur.done, "R7", "host_done", host_done, cur.done);
      chk(dram_a == cur.a, "R2", "dram_a", dram_a, cur.a);
      if (cur.dqoe) chk(dq_out == cur_d, "R6", "dq_out", dq_out, cur_d);
      if (E <= 3) chk(ras_n && cas_n && !dq_oe, "R1", "idle after reset", {ras_n, cas_n, dq_oe}, 3'b110);

      if (!ras_n && prev_ras && cas_n) row_l = dram_a;
      if (!cas_n && prev_cas && !ras_n) begin
        col_l = dram_a[9:0];
        if (!we_n) dram_mem[{row_l, col_l}] = dq_out;
      end
      prev_ras = ras_n; prev_cas = cas_n;
      if (!ras_n && !cas_n && !oe_n)
        dq_in = dram_mem.exists({row_l, col_l}) ? dram_mem[{row_l, col_l}] : 8'h00;
      else
        dq_in = 8'h5A;

      if (host_valid && host_done) begin
        if (cur_wr) ref_mem[cur_a] = cur_d;
        else begin
          exp_rd = ref_mem.exists(cur_a) ? ref_mem[cur_a] : 8'h00;
          chk(host_rdata == exp_rd, "R5", "host_rdata", host_rdata, exp_rd);
        end
        host_valid = 0;
        tx++;
        gap = tx % 4;
      end else if (!host_valid && tx < NTX) begin
        if (gap == 0) begin
          txn(tx, cur_wr, cur_a, cur_d);
          host_valid = 1; host_write = cur_wr; host_addr = cur_a; host_wdata = cur_d;
          waited = !cur_idle || q.size() != 0;
        end else gap--;
      end

      if (q.size() == 0 && cur_idle) begin
        if (mpend) begin
          push_ref(host_valid ? "R9" : "R8");
          if (host_valid) ref_over_host++;
          ref_cnt++;
          mpend = 0;
        end else if (host_valid) begin
          push_host(cur_wr, cur_a, waited ? "R10" : "R3");
          waited = 0;
        end
      end else if (host_valid) waited = 1;

      if (q.size() != 0) begin cur = q.pop_front(); cur_idle = 0; end
      else begin cur = idle_v; cur_idle = 1; end

      if (tx >= NTX) tail++;
    end

    chk(ref_over_host > 0, "R9", "refresh before waiting request", ref_over_host, 1);
    chk(ref_cnt >= 3, "R8", "refresh count", ref_cnt, 3);
    finished = 1;
    report();
    $finish;
  end

endmodule